// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block sits in front of the ALU of a five-stage in-order pipeline. It decides, for each of the two ALU operands, whether the value read from the register file in decode can be used as it is. If not, it substitutes a fresher result from a later stage. Two later results are available. One is the ALU result of the instruction one step ahead, held in the execute/memory register. The other is the value about to be written back by the instruction two steps ahead, held in the memory/writeback register.

The block is purely combinational. For each operand it compares the source register number of the instruction in execute against the destination register numbers of the two later stages. A comparison only counts when that stage's register-write flag is set and its destination is not register zero. It then drives a 2-bit select code and the selected operand value. When both later stages write the same register, the nearer one holds the newer value and wins.

Top module: `opnd_bypass`

## Requirements
- R1: Each select output uses the encoding 2'b00 = register-file value, 2'b01 = memory/writeback value, 2'b10 = execute/memory result. The code 2'b11 never appears. Each operand output equals the value named by its select.
- R2: An operand selects the execute/memory result (2'b10) when that stage's write flag is 1, its destination is nonzero, and its destination equals the operand's source register.
- R3: An operand selects the memory/writeback value (2'b01) when that stage's write flag is 1, its destination is nonzero, its destination equals the source register, and the R2 condition is false for that operand.
- R4: When both later stages would forward to the same operand, the execute/memory result is chosen. This holds in particular for three back-to-back writes to one register.
- R5: A source register of 0 always yields select 2'b00 and the register-file value, whatever the later stages hold.
- R6: A later stage whose write flag is 0 (a bubble) never causes a forward, even if its destination matches.
- R7: Operand A is decided from the first source field and operand B from the second source field. Each is decided without regard to the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a | input | 5 | First source register number of the instruction in execute |
| src_b | input | 5 | Second source register number of the instruction in execute |
| rf_val_a | input | DATA_W | Register-file value latched for operand A |
| rf_val_b | input | DATA_W | Register-file value latched for operand B |
| exm_wr | input | 1 | Register-write flag of the execute/memory stage |
| exm_dst | input | 5 | Destination register of the execute/memory stage |
| exm_res | input | DATA_W | ALU result held in the execute/memory stage |
| mwb_wr | input | 1 | Register-write flag of the memory/writeback stage |
| mwb_dst | input | 5 | Destination register of the memory/writeback stage |
| mwb_res | input | DATA_W | Writeback value held in the memory/writeback stage |
| pick_a | output | 2 | Select code for operand A |
| pick_b | output | 2 | Select code for operand B |
| opnd_a | output | DATA_W | Final ALU operand A |
| opnd_b | output | DATA_W | Final ALU operand B |

## Verification
Every output of this block is due in the same cycle as its inputs: there is no register between the stage inputs and the selects or operands. The bench changes inputs on the falling clock edge only. It reads both selects and both operands one quarter period later, before the next rising edge, so the settled combinational result is compared against a model computed from the requirements. Each scenario task drives one stage pattern per cycle and checks its results in that same cycle.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;

    localparam int REG_AW = 5;

    typedef logic [REG_AW-1:0] regnum_t;

    typedef enum logic [1:0] {
        PICK_RF  = 2'b00,
        PICK_MWB = 2'b01,
        PICK_EXM = 2'b10
    } pick_e;

    typedef struct packed {
        logic    wr;
        regnum_t dst;
    } stage_wr_t;

    function automatic logic stage_hits(stage_wr_t st, regnum_t src);
        return st.wr && (st.dst != '0) && (st.dst == src);
    endfunction

endpackage

// File: rtl/opnd_pick.sv
module opnd_pick
    import opnd_bypass_pkg::*;
(
    input  regnum_t   src,
    input  stage_wr_t near_st,
    input  stage_wr_t far_st,
    output pick_e     pick
);
    logic near_hit;
    logic far_hit;

    always_comb begin
        near_hit = stage_hits(near_st, src);
        far_hit  = stage_hits(far_st, src);
        if (near_hit)
            pick = PICK_EXM;
        else if (far_hit)
            pick = PICK_MWB;
        else
            pick = PICK_RF;
    end

    always_comb begin
        AST_PICK_LEGAL: assert (pick != 2'b11) else $error("illegal pick code"); // R1
    end

endmodule

// File: rtl/opnd_mux.sv
module opnd_mux
    import opnd_bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  pick_e             pick,
    input  logic [DATA_W-1:0] rf_val,
    input  logic [DATA_W-1:0] mwb_val,
    input  logic [DATA_W-1:0] exm_val,
    output logic [DATA_W-1:0] out_val
);
    always_comb begin
        unique case (pick)
            PICK_EXM: out_val = exm_val;
            PICK_MWB: out_val = mwb_val;
            default:  out_val = rf_val;
        endcase
    end
endmodule

// File: rtl/opnd_bypass.sv
module opnd_bypass
    import opnd_bypass_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [REG_AW-1:0] src_a,
    input  logic [REG_AW-1:0] src_b,
    input  logic [DATA_W-1:0] rf_val_a,
    input  logic [DATA_W-1:0] rf_val_b,
    input  logic              exm_wr,
    input  logic [REG_AW-1:0] exm_dst,
    input  logic [DATA_W-1:0] exm_res,
    input  logic              mwb_wr,
    input  logic [REG_AW-1:0] mwb_dst,
    input  logic [DATA_W-1:0] mwb_res,
    output logic [1:0]        pick_a,
    output logic [1:0]        pick_b,
    output logic [DATA_W-1:0] opnd_a,
    output logic [DATA_W-1:0] opnd_b
);
    localparam int NOPS = 2;

    stage_wr_t         exm_st;
    stage_wr_t         mwb_st;
    regnum_t           src_v  [NOPS];
    logic [DATA_W-1:0] rf_v   [NOPS];
    pick_e             pick_v [NOPS];
    logic [DATA_W-1:0] out_v  [NOPS];

    assign exm_st   = '{wr: exm_wr, dst: exm_dst};
    assign mwb_st   = '{wr: mwb_wr, dst: mwb_dst};
    assign src_v[0] = src_a;
    assign src_v[1] = src_b;
    assign rf_v[0]  = rf_val_a;
    assign rf_v[1]  = rf_val_b;

    for (genvar g = 0; g < NOPS; g++) begin : g_lane
        opnd_pick u_pick (
            .src     (src_v[g]),
            .near_st (exm_st),
            .far_st  (mwb_st),
            .pick    (pick_v[g])
        );

        opnd_mux #(.DATA_W(DATA_W)) u_mux (
            .pick    (pick_v[g]),
            .rf_val  (rf_v[g]),
            .mwb_val (mwb_res),
            .exm_val (exm_res),
            .out_val (out_v[g])
        );

        always_comb begin
            if (pick_v[g] == PICK_EXM)
                AST_EXM_DATA: assert (out_v[g] == exm_res) else $error("exm data mismatch"); // R1
            if (pick_v[g] == PICK_MWB)
                AST_MWB_DATA: assert (out_v[g] == mwb_res) else $error("mwb data mismatch"); // R1
            if (src_v[g] == '0)
                AST_ZERO_NOFWD: assert (pick_v[g] == PICK_RF) else $error("reg zero forwarded"); // R5
            if (!exm_wr && !mwb_wr)
                AST_BUBBLE_NOFWD: assert (pick_v[g] == PICK_RF) else $error("bubble forwarded"); // R6
            if (exm_wr && exm_dst == src_v[g] && src_v[g] != '0)
                AST_NEAR_WINS: assert (pick_v[g] == PICK_EXM) else $error("near stage lost"); // R2 R4
            if (pick_v[g] == PICK_MWB)
                AST_FAR_VALID: assert (mwb_wr && mwb_dst == src_v[g]) else $error("bad far pick"); // R3
        end
    end

    assign pick_a = pick_v[0];
    assign pick_b = pick_v[1];
    assign opnd_a = out_v[0];
    assign opnd_b = out_v[1];

endmodule

// File: tb/opnd_bypass_tb_top.sv
`timescale 1ns/1ps
module opnd_bypass_tb_top;
    localparam int DW = 32;
    localparam logic [DW-1:0] RFA = 32'hA0A0_0001;
    localparam logic [DW-1:0] RFB = 32'hB0B0_0002;
    localparam logic [DW-1:0] EXV = 32'hE0E0_0003;
    localparam logic [DW-1:0] WBV = 32'hC0C0_0004;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [4:0]    src_a, src_b, exm_dst, mwb_dst;
    logic [DW-1:0] rf_val_a, rf_val_b, exm_res, mwb_res;
    logic          exm_wr, mwb_wr;
    logic [1:0]    pick_a, pick_b;
    logic [DW-1:0] opnd_a, opnd_b;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    opnd_bypass #(.DATA_W(DW)) dut_i (
        .src_a(src_a), .src_b(src_b), .rf_val_a(rf_val_a), .rf_val_b(rf_val_b),
        .exm_wr(exm_wr), .exm_dst(exm_dst), .exm_res(exm_res),
        .mwb_wr(mwb_wr), .mwb_dst(mwb_dst), .mwb_res(mwb_res),
        .pick_a(pick_a), .pick_b(pick_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    // Spec model: R2 beats R3, neither for register 0 or a cleared write flag.
    function automatic logic [1:0] want_pick(logic [4:0] s);
        if (exm_wr && exm_dst != 0 && exm_dst == s) return 2'b10;
        if (mwb_wr && mwb_dst != 0 && mwb_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [DW-1:0] want_val(logic [1:0] p, logic [DW-1:0] rf);
        return (p == 2'b10) ? EXV : (p == 2'b01) ? WBV : rf;
    endfunction

    task automatic chk(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    // Drive on falling edge, sample a quarter period later (combinational, due same cycle).
    task automatic apply(string tag, logic [4:0] sa, logic [4:0] sb,
                         logic ew, logic [4:0] ed, logic ww, logic [4:0] wd);
        logic [1:0] pa, pb;
        @(negedge clk);
        src_a = sa; src_b = sb; exm_wr = ew; exm_dst = ed; mwb_wr = ww; mwb_dst = wd;
        #1.25;
        pa = want_pick(sa);
        pb = want_pick(sb);
        chk({tag, " pick_a"}, {30'd0, pick_a}, {30'd0, pa});
        chk({tag, " pick_b"}, {30'd0, pick_b}, {30'd0, pb});
        chk({tag, " opnd_a"}, opnd_a, want_val(pa, RFA));
        chk({tag, " opnd_b"}, opnd_b, want_val(pb, RFB));
    endtask

    task automatic t_reset_state();
        apply("R1 idle", 5'd0, 5'd0, 1'b0, 5'd0, 1'b0, 5'd0);
        chk("R1 idle code A", {30'd0, pick_a}, 32'd0);
    endtask

    task automatic t_near_fwd();
        apply("R2 near to A", 5'd3, 5'd4, 1'b1, 5'd3, 1'b0, 5'd0);
        chk("R2 near code", {30'd0, pick_a}, 32'd2);
        apply("R2 near to both", 5'd7, 5'd7, 1'b1, 5'd7, 1'b1, 5'd9);
    endtask

    task automatic t_far_fwd();
        apply("R3 far to B", 5'd1, 5'd12, 1'b1, 5'd5, 1'b1, 5'd12);
        chk("R3 far code", {30'd0, pick_b}, 32'd1);
        apply("R3 far near-miss", 5'd12, 5'd13, 1'b0, 5'd12, 1'b1, 5'd12);
    endtask

    task automatic t_priority();
        // three back-to-back writes to r8: nearest result must win
        apply("R4 triple write", 5'd8, 5'd8, 1'b1, 5'd8, 1'b1, 5'd8);
        chk("R4 near wins", opnd_a, EXV);
        apply("R4 split", 5'd8, 5'd9, 1'b1, 5'd8, 1'b1, 5'd9);
    endtask

    task automatic t_zero_reg();
        apply("R5 zero both stages", 5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0);
        chk("R5 zero opnd_a", opnd_a, RFA);
        apply("R5 zero A only", 5'd0, 5'd6, 1'b1, 5'd0, 1'b1, 5'd6);
    endtask

    task automatic t_bubble();
        apply("R6 bubbles", 5'd10, 5'd11, 1'b0, 5'd10, 1'b0, 5'd11);
        chk("R6 bubble opnd_b", opnd_b, RFB);
        apply("R6 near bubble far live", 5'd14, 5'd2, 1'b0, 5'd14, 1'b1, 5'd14);
    endtask

    task automatic t_independent();
        apply("R7 A near B far", 5'd20, 5'd21, 1'b1, 5'd20, 1'b1, 5'd21);
        apply("R7 A far B near", 5'd21, 5'd20, 1'b1, 5'd20, 1'b1, 5'd21);
        for (int r = 1; r < 32; r += 5)
            apply("R7 sweep", r[4:0], 5'(r + 1), 1'b1, 5'(r + 1), 1'b1, r[4:0]);
    endtask

    initial begin : watchdog
        while (cycles < 5000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        $display("FAIL watchdog actual=%0d expected<5000", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        src_a = 0; src_b = 0; exm_wr = 0; exm_dst = 0; mwb_wr = 0; mwb_dst = 0;
        rf_val_a = RFA; rf_val_b = RFB; exm_res = EXV; mwb_res = WBV;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        t_reset_state();
        t_near_fwd();
        t_far_fwd();
        t_priority();
        t_zero_reg();
        t_bubble();
        t_independent();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule